// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block is the sending half of a synchronous serial port that runs as a clock slave. An external master drives the shift clock on `ext_sck`. The block returns data on `ser_dout`, least significant bit first. It changes the data bit after each falling edge of that clock, so the master can sample it on the rising edge. Words are 8 bits wide, with an optional ninth bit. Because the shift clock comes from outside, shifting goes on while the local core is idle or asleep. The `wake_req` output lets the core be woken when the buffer needs a new word.

Words arrive on a valid/ready write port. The port feeds a one-word holding register that sits in front of the shift register. A word accepted while the shifter is idle goes straight into the shifter and starts at once. A word accepted while the shifter is busy waits in the holding register, and `wr_ready` and `buf_empty` stay low until it moves on. The write port does not hold back a beat. A beat offered while `wr_ready` is low is dropped, not stalled, and `overrun` records the loss. A producer must therefore wait for `wr_ready` before raising `wr_valid`. The external clock is brought into the `clk` domain with a synchronizer chain and a falling-edge detector.

Top module: `sync_slave_tx`

## Requirements
- R1: The transmitter is active only when `port_en`=1, `sync_mode`=1, `clk_src_master`=0, `cont_rx_en`=0, `single_rx_en`=0 and `tx_en`=1. While it is inactive, `wr_ready`=0, `ser_dout`=0 and `buf_empty`=1, and offered writes have no effect.
- R2: Bits leave least significant first. Bit 0 is on `ser_dout` in the first `clk` cycle after the word is loaded into the shifter. Each later bit appears within 4 `clk` cycles after a falling edge of `ext_sck`, and the bit stays unchanged across the rising edge that comes before that falling edge.
- R3: A word accepted while the shifter is idle goes straight into the shifter. `buf_empty` and `wr_ready` stay 1.
- R4: A word accepted while the shifter is busy is held. `buf_empty`=0 and `wr_ready`=0 until the held word moves into the shifter.
- R5: On the falling edge that ends the last bit, a held word moves into the shifter. Its bit 0 follows on `ser_dout` with no idle bit in between, and `buf_empty` returns to 1.
- R6: `nine_bit_en` and `ninth_bit` are sampled when a word is accepted. In 9-bit mode, the sampled `ninth_bit` is sent after bit 7.
- R7: When the last bit ends and no word is pending, `ser_dout` returns to 0 and stays 0.
- R8: `wake_req` is 1 exactly when `irq_en`=1 and `buf_empty`=1. It does not depend on core activity.
- R9: A beat offered (`wr_valid`=1) while active and `wr_ready`=0 is discarded. It never appears on `ser_dout`. It sets `overrun`, which stays set until the transmitter becomes inactive.
- R10: Making the transmitter inactive, for example by clearing `tx_en`, aborts any shift. In the next cycle `ser_dout`=0, `buf_empty`=1 and `overrun`=0.
- R11: After reset, `ser_dout`=0, `buf_empty`=1 and `overrun`=0.
- R12: A word can be accepted in the same cycle as the falling edge that ends the last bit, with the holding register empty. That word goes straight into the shifter, with no idle bit and no stay in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_src_master | input | 1 | 1 = master clock source (transmitter held off), 0 = slave |
| cont_rx_en | input | 1 | Continuous receive enable; must be 0 to send |
| single_rx_en | input | 1 | Single receive enable; must be 0 to send |
| tx_en | input | 1 | Transmit enable; clearing it aborts |
| nine_bit_en | input | 1 | 9-bit word select, sampled at acceptance |
| ninth_bit | input | 1 | Ninth data bit, sampled at acceptance |
| irq_en | input | 1 | Enable for the wake request |
| wr_valid | input | 1 | Write beat offered |
| wr_data | input | 8 | Write data |
| wr_ready | output | 1 | Holding register can take a word |
| ext_sck | input | 1 | External shift clock from the master |
| ser_dout | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding register empty flag |
| wake_req | output | 1 | Wake/interrupt request |
| overrun | output | 1 | Sticky lost-write status |

## Verification
The critical collision is a new write landing in the same `clk` cycle as the synchronized falling edge that ends the last bit. Two things then compete for the shifter: the end of the word and a fresh load. The bench drives `ext_sck` low and counts the two synchronizer edges, then offers the beat exactly in the cycle the edge pulse is live. It checks that the next cycle shows the new word's bit 0 with `buf_empty` still high. It also checks that the whole new word follows without a gap. A second collision, a held word moving into the shifter on that same edge, is judged by `buf_empty` rising in the same cycle as the first bit of the held word.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef struct packed {
    logic              nine;
    logic              ninth;
    logic [DATA_W-1:0] data;
  } tx_word_t;
endpackage

// File: rtl/sstx_sck_sync.sv
module sstx_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  output logic sck_fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], sck_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  // falling edge of the synchronized clock
  assign sck_fall = last_q & ~chain_q[STAGES-1];

  initial begin
    if (STAGES < 2) $error("STAGES must be at least 2");
  end
endmodule

// File: rtl/sstx_hold.sv
module sstx_hold
  import sstx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     put,
  input  tx_word_t put_word,
  input  logic     take,
  input  logic     drop,
  output logic     full,
  output tx_word_t word,
  output logic     overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      word    <= '0;
      overrun <= 1'b0;
    end else if (clear) begin
      full    <= 1'b0;
      word    <= '0;
      overrun <= 1'b0;
    end else begin
      if (put) begin
        full <= 1'b1;
        word <= put_word;
      end else if (take) begin
        full <= 1'b0;
      end
      if (drop) overrun <= 1'b1;
    end
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && !clear) |=> $stable(word)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clear) |=> overrun); // R9
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
  import sstx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     load,
  input  tx_word_t load_word,
  input  logic     shift,
  output logic     busy,
  output logic     last,
  output logic     dout
);
  logic [DATA_W:0]  sr_q;
  logic [CNT_W-1:0] idx_q;
  logic             nine_q;
  logic [CNT_W-1:0] end_idx;

  assign end_idx = nine_q ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign last    = busy & (idx_q == end_idx);
  assign dout    = busy & sr_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      idx_q  <= '0;
      nine_q <= 1'b0;
      busy   <= 1'b0;
    end else if (clear) begin
      sr_q   <= '0;
      idx_q  <= '0;
      nine_q <= 1'b0;
      busy   <= 1'b0;
    end else if (load) begin
      sr_q   <= {load_word.ninth, load_word.data};
      idx_q  <= '0;
      nine_q <= load_word.nine;
      busy   <= 1'b1;
    end else if (busy && shift) begin
      if (last) begin
        busy <= 1'b0;
        sr_q <= '0;
      end else begin
        sr_q  <= {1'b0, sr_q[DATA_W:1]};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> busy); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= CNT_W'(DATA_W))); // R6
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sstx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_src_master,
  input  logic              cont_rx_en,
  input  logic              single_rx_en,
  input  logic              tx_en,
  input  logic              nine_bit_en,
  input  logic              ninth_bit,
  input  logic              irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              ext_sck,
  output logic              ser_dout,
  output logic              buf_empty,
  output logic              wake_req,
  output logic              overrun
);
  logic     active, sck_fall;
  logic     hold_full, sh_busy, sh_last;
  logic     accept, word_end, take_hold, direct, to_hold, load;
  tx_word_t in_word, hold_word, load_word;

  assign active = port_en & sync_mode & ~clk_src_master &
                  ~cont_rx_en & ~single_rx_en & tx_en;

  sstx_sck_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck_in(ext_sck), .sck_fall(sck_fall)
  );

  assign in_word   = '{nine: nine_bit_en, ninth: ninth_bit, data: wr_data};
  assign wr_ready  = active & ~hold_full;
  assign accept    = wr_valid & wr_ready;
  assign word_end  = sck_fall & sh_last;
  assign take_hold = active & word_end & hold_full;
  assign direct    = accept & (~sh_busy | word_end);
  assign to_hold   = accept & ~direct;
  assign load      = direct | take_hold;
  assign load_word = take_hold ? hold_word : in_word;

  sstx_hold hold_i (
    .clk(clk), .rst_n(rst_n), .clear(~active),
    .put(to_hold), .put_word(in_word), .take(take_hold),
    .drop(active & wr_valid & ~wr_ready),
    .full(hold_full), .word(hold_word), .overrun(overrun)
  );

  sstx_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .clear(~active),
    .load(load), .load_word(load_word), .shift(sck_fall),
    .busy(sh_busy), .last(sh_last), .dout(ser_dout)
  );

  assign buf_empty = ~hold_full;
  assign wake_req  = irq_en & buf_empty;

  AST_HOLD_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> sh_busy); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ser_dout); // R1
  AST_EMPTY_RISE_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $rose(buf_empty)) |-> $past(take_hold)); // R5
  AST_NO_DOUBLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(to_hold && take_hold)); // R12
endmodule

// File: tb/sync_slave_tx_tb_top.sv
module sync_slave_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b1, sync_mode = 1'b1, clk_src_master = 1'b0;
  logic cont_rx_en = 1'b0, single_rx_en = 1'b0, tx_en = 1'b1;
  logic nine_bit_en = 1'b0, ninth_bit = 1'b0, irq_en = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic ext_sck = 1'b0;
  logic wr_ready, ser_dout, buf_empty, wake_req, overrun;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_slave_tx dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .clk_src_master(clk_src_master), .cont_rx_en(cont_rx_en),
    .single_rx_en(single_rx_en), .tx_en(tx_en), .nine_bit_en(nine_bit_en),
    .ninth_bit(ninth_bit), .irq_en(irq_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .ext_sck(ext_sck),
    .ser_dout(ser_dout), .buf_empty(buf_empty), .wake_req(wake_req),
    .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic half(input logic lvl);
    @(negedge clk) ext_sck = lvl;
    repeat (8) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, input logic n9, input logic b9);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; nine_bit_en = n9; ninth_bit = b9;
    @(negedge clk);
    wr_valid = 1'b0; nine_bit_en = 1'b0; ninth_bit = 1'b0;
  endtask

  function automatic logic xbit(input logic [7:0] d, input logic b9, input int i);
    return (i == 8) ? b9 : d[i];
  endfunction

  // bits 1..n-1 of the word currently shifting; bit 0 already checked
  task automatic run_rest(input logic [7:0] d, input logic n9, input logic b9);
    int n;
    n = n9 ? 9 : 8;
    for (int i = 1; i < n; i++) begin
      half(1'b1);
      chk("R2 stable over rise", ser_dout, xbit(d, b9, i - 1));
      half(1'b0);
      chk(n9 && i == 8 ? "R6 ninth bit" : "R2 lsb-first bit", ser_dout, xbit(d, b9, i));
    end
  endtask

  task automatic send(input logic [7:0] d, input logic n9, input logic b9);
    put(d, n9, b9);
    chk("R3 direct load bit0", ser_dout, d[0]);
    chk("R3 empty stays high", buf_empty, 1'b1);
    run_rest(d, n9, b9);
    half(1'b1);
    half(1'b0);
    chk("R7 idle low", ser_dout, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 dout", ser_dout, 1'b0);
    chk("R11 empty", buf_empty, 1'b1);
    chk("R11 overrun", overrun, 1'b0);
    chk("R1 ready when active", wr_ready, 1'b1);
    chk("R8 wake off", wake_req, 1'b0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R8 wake on", wake_req, 1'b1);

    // exhaustive 8-bit sweep, then 9-bit sweep with ninth = parity
    for (int v = 0; v < 256; v++) send(8'(v), 1'b0, 1'b0);
    for (int v = 0; v < 256; v += 2) send(8'(v), 1'b1, ^8'(v));

    // double buffering, overrun, wake
    put(8'hA5, 1'b0, 1'b0);
    chk("R3 A bit0", ser_dout, 1'b1);
    put(8'h3C, 1'b1, 1'b1);
    chk("R4 empty low", buf_empty, 1'b0);
    chk("R4 ready low", wr_ready, 1'b0);
    chk("R8 wake low while held", wake_req, 1'b0);
    put(8'hFF, 1'b0, 1'b0);
    chk("R9 overrun set", overrun, 1'b1);
    run_rest(8'hA5, 1'b0, 1'b0);
    half(1'b1);
    half(1'b0);
    chk("R5 held bit0 no gap", ser_dout, 1'b0);
    chk("R5 empty rises", buf_empty, 1'b1);
    chk("R8 wake rises", wake_req, 1'b1);
    chk("R9 overrun sticky", overrun, 1'b1);
    run_rest(8'h3C, 1'b1, 1'b1);
    half(1'b1);
    half(1'b0);
    chk("R9 dropped word never sent", ser_dout, 1'b0);
    half(1'b1);
    half(1'b0);
    chk("R9 still idle", ser_dout, 1'b0);

    // same-cycle: write lands on the final falling-edge pulse
    put(8'h81, 1'b0, 1'b0);
    run_rest(8'h81, 1'b0, 1'b0);
    half(1'b1);
    @(negedge clk) ext_sck = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h6B;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R12 direct bit0", ser_dout, 1'b1);
    chk("R12 not held", buf_empty, 1'b1);
    repeat (5) @(negedge clk);
    run_rest(8'h6B, 1'b0, 1'b0);
    half(1'b1);
    half(1'b0);
    chk("R12 R7 idle after", ser_dout, 1'b0);

    // abort
    put(8'hFF, 1'b0, 1'b0);
    put(8'h0F, 1'b0, 1'b0);
    put(8'h11, 1'b0, 1'b0);
    chk("R10 pre overrun", overrun, 1'b1);
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk);
    chk("R10 dout low", ser_dout, 1'b0);
    chk("R10 empty", buf_empty, 1'b1);
    chk("R10 overrun cleared", overrun, 1'b0);
    @(negedge clk) tx_en = 1'b1;
    send(8'h5A, 1'b0, 1'b0);

    // gating: each condition alone holds the transmitter off
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      port_en = (c != 0); sync_mode = (c != 1); clk_src_master = (c == 2);
      cont_rx_en = (c == 3); single_rx_en = (c == 4); tx_en = (c != 5);
      @(negedge clk);
      chk("R1 ready low", wr_ready, 1'b0);
      put(8'hFF, 1'b0, 1'b0);
      chk("R1 write ignored dout", ser_dout, 1'b0);
      chk("R1 empty", buf_empty, 1'b1);
      chk("R1 no overrun", overrun, 1'b0);
    end
    @(negedge clk);
    port_en = 1'b1; sync_mode = 1'b1; clk_src_master = 1'b0;
    cont_rx_en = 1'b0; single_rx_en = 1'b0; tx_en = 1'b1;
    @(negedge clk);
    chk("R1 ready restored", wr_ready, 1'b1);
    chk("R1 still idle", ser_dout, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #600us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule